// File: doc/BRIEF.md
# Scrambling Byte Sampler for a Debiased Random Bit Stream

This block turns a serial stream of debiased random bits into random bytes. Each accepted bit goes into an 8-bit working register through a feedback shift: the register moves one place towards its most significant bit, and the new least significant bit is the incoming bit XORed with the bit that falls out of the top. A byte is not taken from the first eight bits. The register starts from zero and absorbs 64 accepted bits, so every output bit depends on many input bits and any remaining bias in the stream is spread out.

Input bits arrive on a valid/ready pair. Ready follows the enable pin, so the only back-pressure is "disabled". While enabled the block takes a bit on every cycle in which valid is high. While valid is low it holds its state and waits. The output has no ready. A finished byte is shown on the data pins with a valid strobe that lasts one cycle, and the consumer must capture it in that cycle. The data pins keep the byte until the next byte replaces it. Pulling enable low throws away any partly built byte and clears the outputs.

Top module: `scr_byte_sampler`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, `out_valid` is 0 and `out_data` is 0.
- R2: `in_ready` equals `enable`. A bit offered while `enable` is low is not taken and has no effect on any later byte.
- R3: The working register is zero at the start of every byte. For each accepted bit b (accepted means `in_valid` and `in_ready` are both high at a clock edge), the register w becomes {w[6:0], b ^ w[7]}. The first accepted bit of a byte is bit 0 of the bench's 64-bit pattern.
- R4: Each byte uses exactly 64 accepted bits. `out_valid` is 0 before the 64th bit and rises in the cycle right after the clock edge that accepts the 64th bit, with `out_data` equal to the register value after that bit.
- R5: `out_valid` is high for exactly one cycle for each byte.
- R6: In a cycle where `in_valid` is low, the working register and the bit count keep their values, and the level of `in_bit` is ignored. A byte fed with idle gaps equals the same byte fed without gaps.
- R7: Pulling `enable` low clears the working register, the bit count, `out_data` and `out_valid` at the next edge. After enable returns, the next byte is built only from bits accepted after that point.
- R8: Between valid pulses `out_data` keeps the last byte delivered.
- R9: The working register restarts from zero in the same edge that delivers a byte, so a bit can be accepted in every cycle. With a bit on every cycle, pulses come 64 cycles apart. With a bit every second cycle, they come 128 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the sampler; low clears all state |
| in_valid | input | 1 | An input bit is offered |
| in_bit | input | 1 | Debiased random bit |
| in_ready | output | 1 | Sampler can take a bit (equals enable) |
| out_data | output | 8 | Latest random byte |
| out_valid | output | 1 | One-cycle strobe for a new byte |

## Verification
The assertions check these rules on every cycle: the working register and the bit count hold while no bit is accepted, the register shifts by one place for each accepted bit and is zero after a byte completes, disabling clears the count, the data pins hold between pulses, and the strobe never stays high for two cycles in a row. Other behaviour needs whole scenarios, and only the bench shows it. That covers the exact byte value for a known 64-bit pattern, the cycle in which the pulse appears, the equivalence of gapped and gap-free feeding, the fact that bits offered while disabled are ignored, the discarding of a partial byte, and the 64- and 128-cycle pulse spacing.

// File: rtl/scr_sampler_pkg.sv
package scr_sampler_pkg;
  localparam int unsigned DEF_BYTE_W   = 8;
  localparam int unsigned DEF_BITS_PER = 64;
endpackage

// File: rtl/sbs_bit_counter.sv
module sbs_bit_counter #(
  parameter int unsigned COUNT = 64,
  localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic wrap
);
  logic [CW-1:0] cnt;

  assign wrap = step && (cnt == CW'(COUNT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step) begin
      if (wrap) cnt <= '0;
      else      cnt <= cnt + CW'(1);
    end
  end

  // R6: count holds while no bit is accepted
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(cnt));
  // R7: disable clears the count
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/sbs_mix_reg.sv
module sbs_mix_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         restart,
  input  logic         bit_in,
  output logic [W-1:0] next_val
);
  logic [W-1:0] work;

  assign next_val = {work[W-2:0], bit_in ^ work[W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work <= '0;
    end else if (clear) begin
      work <= '0;
    end else if (step) begin
      if (restart) work <= '0;
      else         work <= next_val;
    end
  end

  // R3: one place of shift per accepted bit
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step && !restart) |=> (work[W-1:1] == $past(work[W-2:0])));
  // R3: register starts each byte from zero
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step && restart) |=> (work == '0));
  // R6: register holds without an accepted bit
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(work));
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] data,
  output logic         valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (clear) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) data <= load_val;
    end
  end

  // R5: strobe never lasts two cycles
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R8: data holds between deliveries
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load) |=> $stable(data));
  // R4: completed byte is strobed in the next cycle
  p_load_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load) |=> valid);
endmodule

// File: rtl/scr_byte_sampler.sv
module scr_byte_sampler
  import scr_sampler_pkg::*;
#(
  parameter int unsigned BYTE_W   = DEF_BYTE_W,
  parameter int unsigned BITS_PER = DEF_BITS_PER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid
);
  logic              accept;
  logic              clear;
  logic              wrap;
  logic [BYTE_W-1:0] next_val;

  assign in_ready = enable;
  assign clear    = !enable;
  assign accept   = enable && in_valid;

  sbs_bit_counter #(.COUNT(BITS_PER)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .step  (accept),
    .wrap  (wrap)
  );

  sbs_mix_reg #(.W(BYTE_W)) u_mix (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .step     (accept),
    .restart  (wrap),
    .bit_in   (in_bit),
    .next_val (next_val)
  );

  sbs_out_stage #(.W(BYTE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load     (wrap),
    .load_val (next_val),
    .data     (out_data),
    .valid    (out_valid)
  );

  // R7: disabled sampler delivers nothing and clears its data
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && out_data == '0));
endmodule

// File: tb/scr_byte_sampler_bench.sv
module scr_byte_sampler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  scr_byte_sampler u_scr_byte_sampler (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [7:0] model(input logic [63:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 64; i++) r = {r[6:0], v[i] ^ r[7]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed_byte(input logic [63:0] v, input int gap);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (i == 63) chk(out_valid == 1'b0, "R4 no early strobe", out_valid, 0);
      in_valid = 1'b1;
      in_bit   = v[i];
      if (gap > 0 && i < 63) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_bit   = ~in_bit;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R4 strobe after 64th bit", out_valid, 1);
    chk(out_data == model(v), "R3 byte value", out_data, model(v));
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 single-cycle strobe", out_valid, 0);
    chk(out_data == model(v), "R8 data held", out_data, model(v));
  endtask

  task automatic t_reset();
    #5;
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(out_data == 8'h00, "R1 data in reset", out_data, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_data == 8'h00, "R1 data after reset", out_data, 0);
    chk(in_ready == 1'b0, "R2 ready low when disabled", in_ready, 0);
  endtask

  task automatic t_ignore_disabled();
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = i[0];
      if (out_valid) chk(1'b0, "R2 strobe while disabled", 1, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0 && out_data == 8'h00, "R2 disabled bits ignored", out_data, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready follows enable", in_ready, 1);
    feed_byte(64'h0123_4567_89AB_CDEF, 0);
  endtask

  task automatic t_patterns();
    feed_byte(64'hFFFF_FFFF_FFFF_FFFF, 0);
    feed_byte(64'hAAAA_5555_AAAA_5555, 0);
    feed_byte(64'hDEAD_BEEF_CAFE_F00D, 0);
  endtask

  task automatic t_gaps();
    // R6: idle gaps with toggling in_bit do not change the byte
    feed_byte(64'h1357_9BDF_2468_ACE0, 3);
    feed_byte(64'h0F1E_2D3C_4B5A_6978, 1);
  endtask

  task automatic t_abort_partial();
    logic [63:0] junk = 64'hFEDC_BA98_7654_3210;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = junk[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    enable   = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 valid cleared", out_valid, 0);
    chk(out_data == 8'h00, "R7 data cleared", out_data, 0);
    enable = 1'b1;
    feed_byte(64'h8421_1248_8421_1248, 0);
  endtask

  task automatic t_spacing(input int step, input logic [63:0] a, input logic [63:0] b);
    int first = -1;
    int second = -1;
    int npulse = 0;
    logic [127:0] bits = {b, a};
    int k = 0;
    for (int c = 0; c < 128 * step + 4; c++) begin
      @(negedge clk);
      if (out_valid) begin
        npulse++;
        if (first < 0) begin
          first = c;
          chk(out_data == model(a), "R9 first byte", out_data, model(a));
        end else begin
          second = c;
          chk(out_data == model(b), "R9 second byte", out_data, model(b));
        end
      end
      if ((c % step) == 0 && k < 128) begin
        in_valid = 1'b1;
        in_bit   = bits[k];
        k++;
      end else begin
        in_valid = 1'b0;
      end
    end
    in_valid = 1'b0;
    chk(npulse == 2, "R9 pulse count", npulse, 2);
    chk(second - first == 64 * step, "R9 pulse spacing", second - first, 64 * step);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ignore_disabled();
    t_patterns();
    t_gaps();
    t_abort_partial();
    t_spacing(1, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF);
    t_spacing(2, 64'hC3C3_3C3C_A5A5_5A5A, 64'h7E81_7E81_0FF0_F00F);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule